// File: doc/BRIEF.md
# Pass/Fail Test Flow Sequencer

This block walks a fixed, ordered chain of test steps and hands each one, in turn, to an external test engine. For the current step it raises a single-cycle start request with the step index and then waits until the engine presents a result code while its result-valid line is high. A passing code moves the flow along the chain. Any other code ends the flow at once. The chain begins with a setup step whose pass leads into the first real test. With the default of four steps, a typical chain is setup, power-up, configuration load and functional check.

When a flow ends, the block pulses a done strobe for one cycle. The strobe carries an overall result (0 only when every step passed) and a bin code that identifies the step that stopped the flow and how it stopped. Two saturating counters tally accepted passing and failing results across runs. A new run never resets them; only a dedicated clear input does. The step chain, with a next-step link, a last-step flag and two bin codes per step, is built as a small table from parameters.

Top module: `flow_seq_top`

## Requirements
- R1: After reset the block is idle (busy_o low), issues no request, shows no done pulse, both counters read 0, result_o is 0 and bin_o is 0x00.
- R2: A high run_i while idle is taken at that clock edge, and eng_req_o is high for exactly one cycle after that edge with eng_step_o equal to 0.
- R3: run_i is ignored while busy_o is high. It neither restarts the flow nor changes the step index.
- R4: A result code is taken only at an edge where the block is waiting and eng_valid_i is high. Codes presented with eng_valid_i low have no effect on counters, step or done.
- R5: A taken code 0 on a step that is not the last adds one to pass_cnt_o, and the request for the next step (index plus one) rises in the cycle after the accepting edge.
- R6: A taken code 0 on the last step (index NUM_STEPS-1) adds one to pass_cnt_o, and in the cycle after the accepting edge done_o is high with result_o 0 and bin_o 0x00.
- R7: A taken code 1 on step k adds one to fail_cnt_o, and in the cycle after the accepting edge done_o is high with result_o 1 and bin_o 0x10+k. No later step is requested.
- R8: A taken code 2, or the unused code 3, on step k counts and ends the flow like a failure, but bin_o is 0x20+k.
- R9: Each counter stops at 2^CNT_W-1 and does not wrap.
- R10: clr_cnt_i high at an edge sets both counters to 0 after that edge, and it wins over an increment taken at the same edge. Starting a run leaves the counters unchanged.
- R11: done_o lasts exactly one cycle, and busy_o is already low in that cycle, so a run_i high in that same cycle starts a new flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Begin a flow when idle |
| clr_cnt_i | input | 1 | Clear both counters |
| eng_req_o | output | 1 | One-cycle start request to the test engine |
| eng_step_o | output | IDX_W | Index of the step being requested |
| eng_valid_i | input | 1 | Engine result is valid |
| eng_code_i | input | 2 | Engine result code: 0 pass, 1 fail, 2 error, 3 treated as error |
| busy_o | output | 1 | A flow is in progress |
| done_o | output | 1 | One-cycle end-of-flow strobe |
| result_o | output | 1 | Overall result: 0 all passed, 1 stopped by a non-pass |
| bin_o | output | 8 | Bin code of the finished flow |
| pass_cnt_o | output | CNT_W | Saturating count of taken passing results |
| fail_cnt_o | output | CNT_W | Saturating count of taken failing results |

## Verification
Two pairs of functions can land in the same edge. A counter clear can meet a result being taken, and a new run request can arrive in the cycle the done strobe shows. The bench raises clr_cnt_i in the exact cycle it presents a valid code, then expects both counters at zero with the increment lost. It also raises run_i during the done cycle and expects the next step-0 request one cycle later. A behavioural model, stepped every clock, predicts every output, and each cycle of the DUT is compared against it.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam int BIN_W = 8;

    localparam logic [BIN_W-1:0] PASS_BIN = 8'h00;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam logic [1:0] CODE_PASS = 2'd0;
    localparam logic [1:0] CODE_FAIL = 2'd1;

    typedef struct packed {
        logic             last;
        logic [BIN_W-1:0] fail_bin;
        logic [BIN_W-1:0] err_bin;
    } step_info_t;

    function automatic logic [BIN_W-1:0] fail_bin_of(input int idx);
        return 8'h10 + BIN_W'(idx);
    endfunction

    function automatic logic [BIN_W-1:0] err_bin_of(input int idx);
        return 8'h20 + BIN_W'(idx);
    endfunction

endpackage

// File: rtl/flow_step_table.sv
module flow_step_table
    import flow_pkg::*;
#(
    parameter int NUM_STEPS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] next_o,
    output step_info_t       info_o
);

    logic [IDX_W-1:0] next_tab [NUM_STEPS];
    step_info_t       info_tab [NUM_STEPS];

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_entry
        localparam bit IS_LAST = (g == NUM_STEPS - 1);
        assign next_tab[g] = IS_LAST ? '0 : IDX_W'(g + 1);
        assign info_tab[g] = step_info_t'{
            last:     IS_LAST,
            fail_bin: fail_bin_of(g),
            err_bin:  err_bin_of(g)
        };
    end

    always_comb begin
        next_o = '0;
        info_o = step_info_t'{last: 1'b1, fail_bin: fail_bin_of(0), err_bin: err_bin_of(0)};
        for (int i = 0; i < NUM_STEPS; i++) begin
            if (idx_i == IDX_W'(i)) begin
                next_o = next_tab[i];
                info_o = info_tab[i];
            end
        end
    end

endmodule

// File: rtl/flow_sat_counter.sv
module flow_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && cnt_o != TOP) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/flow_seq_top.sv
module flow_seq_top
    import flow_pkg::*;
#(
    parameter int NUM_STEPS = 4,
    parameter int CNT_W     = 4,
    localparam int IDX_W    = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             clr_cnt_i,
    output logic             eng_req_o,
    output logic [IDX_W-1:0] eng_step_o,
    input  logic             eng_valid_i,
    input  logic [1:0]       eng_code_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             result_o,
    output logic [BIN_W-1:0] bin_o,
    output logic [CNT_W-1:0] pass_cnt_o,
    output logic [CNT_W-1:0] fail_cnt_o
);

    seq_state_e       state_q;
    logic [IDX_W-1:0] step_q;
    logic [IDX_W-1:0] next_step;
    step_info_t       info;
    logic             taken;
    logic             pass_hit;
    logic             fail_hit;

    flow_step_table #(
        .NUM_STEPS(NUM_STEPS),
        .IDX_W    (IDX_W)
    ) u_table (
        .idx_i (step_q),
        .next_o(next_step),
        .info_o(info)
    );

    always_comb begin
        taken    = (state_q == ST_WAIT) && eng_valid_i;
        pass_hit = taken && (eng_code_i == CODE_PASS);
        fail_hit = taken && (eng_code_i != CODE_PASS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            done_o   <= 1'b0;
            result_o <= 1'b0;
            bin_o    <= PASS_BIN;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (run_i) begin
                        step_q  <= '0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (pass_hit && !info.last) begin
                        step_q  <= next_step;
                        state_q <= ST_ISSUE;
                    end else if (pass_hit) begin
                        done_o   <= 1'b1;
                        result_o <= 1'b0;
                        bin_o    <= PASS_BIN;
                        state_q  <= ST_IDLE;
                    end else if (fail_hit) begin
                        done_o   <= 1'b1;
                        result_o <= 1'b1;
                        bin_o    <= (eng_code_i == CODE_FAIL) ? info.fail_bin : info.err_bin;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    flow_sat_counter #(.W(CNT_W)) u_pass_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr_i(clr_cnt_i),
        .inc_i(pass_hit),
        .cnt_o(pass_cnt_o)
    );

    flow_sat_counter #(.W(CNT_W)) u_fail_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr_i(clr_cnt_i),
        .inc_i(fail_hit),
        .cnt_o(fail_cnt_o)
    );

    assign eng_req_o  = (state_q == ST_ISSUE);
    assign eng_step_o = step_q;
    assign busy_o     = (state_q != ST_IDLE);

endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
    parameter int CNT_W = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             run_i,
    input logic             clr_cnt_i,
    input logic             eng_req_o,
    input logic [IDX_W-1:0] eng_step_o,
    input logic             eng_valid_i,
    input logic [1:0]       eng_code_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             result_o,
    input logic [CNT_W-1:0] pass_cnt_o,
    input logic [CNT_W-1:0] fail_cnt_o
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic waiting;
    assign waiting = busy_o && !eng_req_o;

    p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
        eng_req_o |=> !eng_req_o);

    p_start_step0_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && run_i) |=> (eng_req_o && eng_step_o == '0));

    p_busy_keeps_step_r3: assert property (@(posedge clk) disable iff (rst)
        (waiting && !eng_valid_i && run_i) |=> (busy_o && $stable(eng_step_o)));

    p_no_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (waiting && !eng_valid_i && !clr_cnt_i) |=>
            (!done_o && $stable(pass_cnt_o) && $stable(fail_cnt_o)));

    p_fail_ends_r7: assert property (@(posedge clk) disable iff (rst)
        (waiting && eng_valid_i && eng_code_i != 2'd0) |=> (done_o && result_o && !eng_req_o));

    p_fail_count_r8: assert property (@(posedge clk) disable iff (rst)
        (waiting && eng_valid_i && eng_code_i != 2'd0 && !clr_cnt_i && fail_cnt_o != TOP)
            |=> (fail_cnt_o == $past(fail_cnt_o) + 1'b1));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (pass_cnt_o == TOP && !clr_cnt_i) |=> (pass_cnt_o == TOP));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr_cnt_i |=> (pass_cnt_o == '0 && fail_cnt_o == '0));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o ##1 !done_o));

endmodule

bind flow_seq_top flow_seq_chk #(
    .CNT_W(CNT_W),
    .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .clr_cnt_i  (clr_cnt_i),
    .eng_req_o  (eng_req_o),
    .eng_step_o (eng_step_o),
    .eng_valid_i(eng_valid_i),
    .eng_code_i (eng_code_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .pass_cnt_o (pass_cnt_o),
    .fail_cnt_o (fail_cnt_o)
);

// File: tb/flow_seq_top_test.sv
module flow_seq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP      = 4;
    localparam int CW         = 4;
    localparam int CMAX       = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_i = 1'b0;
    logic       clr_cnt_i = 1'b0;
    logic       eng_valid_i = 1'b0;
    logic [1:0] eng_code_i = 2'd0;
    logic       eng_req_o;
    logic [1:0] eng_step_o;
    logic       busy_o, done_o, result_o;
    logic [7:0] bin_o;
    logic [CW-1:0] pass_cnt_o, fail_cnt_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_tag = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    flow_seq_top #(.NUM_STEPS(NSTEP), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .run_i(run_i), .clr_cnt_i(clr_cnt_i),
        .eng_req_o(eng_req_o), .eng_step_o(eng_step_o),
        .eng_valid_i(eng_valid_i), .eng_code_i(eng_code_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .bin_o(bin_o),
        .pass_cnt_o(pass_cnt_o), .fail_cnt_o(fail_cnt_o)
    );

    // behavioural model: 0 idle, 1 requesting, 2 waiting
    int m_phase = 0, m_step = 0, m_pass = 0, m_fail = 0, m_bin = 0;
    bit m_done = 0, m_res = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_step = 0; m_pass = 0; m_fail = 0;
            m_done = 0; m_res = 0; m_bin = 0;
        end else begin
            m_done = 0;
            if (m_phase == 2 && eng_valid_i) begin
                if (eng_code_i == 2'd0) begin
                    if (m_pass < CMAX) m_pass++;
                    if (m_step == NSTEP - 1) begin
                        m_done = 1; m_res = 0; m_bin = 0; m_phase = 0;
                    end else begin
                        m_step++; m_phase = 1;
                    end
                end else begin
                    if (m_fail < CMAX) m_fail++;
                    m_done = 1; m_res = 1;
                    m_bin = ((eng_code_i == 2'd1) ? 16 : 32) + m_step;
                    m_phase = 0;
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (m_phase == 0 && run_i) begin
                m_step = 0; m_phase = 1;
            end
            if (clr_cnt_i) begin
                m_pass = 0; m_fail = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(eng_req_o == (m_phase == 1), cur_tag, "eng_req_o", int'(eng_req_o), int'(m_phase == 1));
        if (m_phase == 1) chk(int'(eng_step_o) == m_step, cur_tag, "eng_step_o", int'(eng_step_o), m_step);
        chk(busy_o == (m_phase != 0), cur_tag, "busy_o", int'(busy_o), int'(m_phase != 0));
        chk(done_o == m_done, cur_tag, "done_o", int'(done_o), int'(m_done));
        chk(result_o == m_res, cur_tag, "result_o", int'(result_o), int'(m_res));
        chk(int'(bin_o) == m_bin, cur_tag, "bin_o", int'(bin_o), m_bin);
        chk(int'(pass_cnt_o) == m_pass, cur_tag, "pass_cnt_o", int'(pass_cnt_o), m_pass);
        chk(int'(fail_cnt_o) == m_fail, cur_tag, "fail_cnt_o", int'(fail_cnt_o), m_fail);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    // answer the pending request; req is visible on entry
    task automatic respond(input int code, input int dly, input bit poke_run, input bit clr_at);
        eng_valid_i = 0;
        tick();
        for (int d = 0; d < dly; d++) begin
            eng_code_i = 2'd1;   // junk while not valid (R4)
            run_i = poke_run;    // ignored while busy (R3)
            tick();
        end
        run_i = 0;
        eng_valid_i = 1;
        eng_code_i = 2'(code);
        clr_cnt_i = clr_at;
        tick();
        eng_valid_i = 0;
        eng_code_i = 2'd0;
        clr_cnt_i = 0;
    endtask

    task automatic run_flow(input int c0, input int c1, input int c2, input int c3,
                            input int dly, input bit poke_run, input int clr_step,
                            input int gap, input string tag);
        int codes[4];
        codes = '{c0, c1, c2, c3};
        cur_tag = tag;
        run_i = 1;
        tick();
        run_i = 0;
        for (int s = 0; s < NSTEP; s++) begin
            respond(codes[s], dly, poke_run, s == clr_step);
            if (codes[s] != 0) break;
        end
        for (int g = 0; g < gap; g++) tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        cur_tag = "R1";
        chk(!busy_o && !eng_req_o && !done_o, "R1", "idle after reset", int'(busy_o), 0);
        chk(pass_cnt_o == 0 && fail_cnt_o == 0, "R1", "counters after reset", int'(pass_cnt_o), 0);
        chk(bin_o == 8'h00 && !result_o, "R1", "bin after reset", int'(bin_o), 0);

        run_flow(0, 0, 0, 0, 0, 0, -1, 2, "R6");
        chk(pass_cnt_o == 4, "R5", "passes after full run", int'(pass_cnt_o), 4);
        chk(result_o == 0 && bin_o == 8'h00, "R6", "pass verdict", int'(bin_o), 0);

        run_flow(0, 0, 1, 0, 3, 1, -1, 2, "R3");
        chk(bin_o == 8'h12 && result_o, "R7", "fail bin step 2", int'(bin_o), 8'h12);
        chk(fail_cnt_o == 1 && pass_cnt_o == 6, "R10", "run does not clear", int'(pass_cnt_o), 6);

        run_flow(2, 0, 0, 0, 1, 0, -1, 1, "R8");
        chk(bin_o == 8'h20, "R8", "error bin step 0", int'(bin_o), 8'h20);
        run_flow(0, 0, 0, 3, 2, 0, -1, 0, "R8");
        chk(bin_o == 8'h23, "R8", "code 3 bin step 3", int'(bin_o), 8'h23);

        // back-to-back start on the done cycle
        run_flow(0, 1, 0, 0, 0, 0, -1, 0, "R11");
        chk(done_o && !busy_o, "R11", "done with idle", int'(busy_o), 0);
        run_flow(0, 0, 0, 0, 1, 0, -1, 2, "R11");

        // clear colliding with a taken result
        run_flow(0, 0, 0, 0, 1, 0, 3, 1, "R10");
        chk(pass_cnt_o == 0 && fail_cnt_o == 0, "R10", "clear wins", int'(pass_cnt_o), 0);
        cur_tag = "R10";
        clr_cnt_i = 1; tick(); clr_cnt_i = 0; tick();

        for (int k = 0; k < 5; k++) run_flow(0, 0, 0, 0, 0, 0, -1, 1, "R9");
        chk(int'(pass_cnt_o) == CMAX, "R9", "pass saturates", int'(pass_cnt_o), CMAX);
        for (int k = 0; k < 17; k++) run_flow(1, 0, 0, 0, 0, 0, -1, 0, "R9");
        tick();
        chk(int'(fail_cnt_o) == CMAX, "R9", "fail saturates", int'(fail_cnt_o), CMAX);
        chk(bin_o == 8'h10, "R7", "fail bin step 0", int'(bin_o), 8'h10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule